// File: doc/BRIEF.md
# Link Request Router

This block sits in each node of a distributed-memory multiprocessor and moves memory transaction packets between the node and the 32-bit link buses it is attached to. Every packet carries a global address made of a destination node number and a word address inside that node's memory. A packet whose node number matches this node is delivered to the local memory side. Any other packet is sent out on the link that a loadable topology table names for that node number. Packets that only pass through this node on their way elsewhere are handled the same way.

A read travels as two unrelated packets. The first is a read request that carries the address. The second is a read return that the target node sends later. The return carries the requester's node number in its node field and a tag, so the router forwards it exactly like any other packet. No path is ever held open while a read waits for its data, and this is what keeps the network free of deadlock. A write carries its address and data in one packet.

Each output has a two-entry buffer. When a buffer is full, every source aimed at it is held with ready low, and no packet is dropped.

Top module: `lnk_router`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, no output presents a valid packet and every topology table entry reads as link 0.
- R2: A packet whose node field (bits 61:56 of the 74-bit packet) equals `my_node` appears unchanged on the local delivery port in the cycle after it is accepted.
- R3: A packet for any other node appears unchanged, one cycle after acceptance, on the link whose index the table holds for that node number. This holds for packets arriving on a link as well as for packets injected locally.
- R4: A table write takes effect on the cycle after the write strobe. A packet accepted in the same cycle as the write is routed with the old entry.
- R5: Each output holds at most two packets and delivers them in the order they were accepted. When it is full, any source aimed at it sees ready low and must hold its packet until space frees up, so nothing is lost.
- R6: When several sources aim at one output in the same cycle, at most one is accepted. Links win in ascending index order, and the local injection port has the lowest priority.
- R7: The packet kind (bits 73:72: 01 write, 10 read request, 11 read return) and all other fields pass through unchanged. A read return is routed by its node field like any other packet, so a request and its return are independent transfers.
- R8: Sources aimed at different outputs are all accepted in the same cycle.
- R9: While an output is valid and its ready input is low, the output stays valid and its packet stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_node | input | 6 | Node number of this node, held static |
| map_we | input | 1 | Topology table write strobe |
| map_node | input | 6 | Table entry to write |
| map_link | input | 2 | Outgoing link index to store |
| lk_rx_valid | input | 4 | Packet offered on each incoming link |
| lk_rx_ready | output | 4 | Incoming link packet accepted |
| lk_rx_pkt | input | 4x74 | Incoming link packets |
| lk_tx_valid | output | 4 | Packet waiting on each outgoing link |
| lk_tx_ready | input | 4 | Outgoing link takes the packet |
| lk_tx_pkt | output | 4x74 | Outgoing link packets |
| loc_rx_valid | input | 1 | Packet injected by this node |
| loc_rx_ready | output | 1 | Injected packet accepted |
| loc_rx_pkt | input | 74 | Injected packet |
| loc_tx_valid | output | 1 | Packet for this node waiting |
| loc_tx_ready | input | 1 | This node takes the packet |
| loc_tx_pkt | output | 74 | Packet delivered to this node |

## Verification
The bench drives inputs after the falling edge and compares results shortly after it. A source's ready is due in the same cycle it is offered, because it is combinational from the buffer fill levels and the competing requests. An accepted packet is due at the head of its output one edge later. A table write changes routing one edge after the strobe. The bench's behavioural model updates its queues and table only at the rising edge, so each expected value is the one due at that point.

// File: rtl/lnk_pkg.sv
`timescale 1ns/1ps
package lnk_pkg;
    localparam int LNK_NODE_W = 6;
    localparam int LNK_WORD_W = 24;
    localparam int LNK_DATA_W = 32;
    localparam int LNK_TAG_W  = 4;
    localparam int LNK_NLINK  = 4;

    typedef enum logic [1:0] {
        K_NONE  = 2'b00,
        K_WRITE = 2'b01,
        K_RDREQ = 2'b10,
        K_RDRET = 2'b11
    } pkt_kind_e;

    typedef struct packed {
        pkt_kind_e               kind;
        logic [LNK_NODE_W-1:0]   src;
        logic [LNK_TAG_W-1:0]    tag;
        logic [LNK_NODE_W-1:0]   node;
        logic [LNK_WORD_W-1:0]   word;
        logic [LNK_DATA_W-1:0]   data;
    } pkt_t;

    localparam int PKT_W = $bits(pkt_t);

    function automatic int unsigned width_of(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/lnk_route_map.sv
`timescale 1ns/1ps
module lnk_route_map import lnk_pkg::*; #(
    parameter int NLINK  = LNK_NLINK,
    parameter int NSRC   = LNK_NLINK + 1,
    parameter int PORT_W = 3,
    parameter int LINK_W = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [LNK_NODE_W-1:0]            wr_node,
    input  logic [LINK_W-1:0]                wr_link,
    input  logic [LNK_NODE_W-1:0]            my_node,
    input  logic [NSRC-1:0][LNK_NODE_W-1:0]  q_node,
    output logic [NSRC-1:0][PORT_W-1:0]      q_port
);
    localparam int NENT = 1 << LNK_NODE_W;

    logic [LINK_W-1:0] tbl [NENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NENT; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_node] <= wr_link;
        end
    end

    // Local destination maps to the output just past the links.
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            if (q_node[s] == my_node) q_port[s] = PORT_W'(NLINK);
            else                      q_port[s] = PORT_W'(tbl[q_node[s]]);
        end
    end
endmodule

// File: rtl/lnk_arb.sv
`timescale 1ns/1ps
module lnk_arb #(
    parameter int NSRC   = 5,
    parameter int NOUT   = 5,
    parameter int PORT_W = 3,
    parameter int SRC_W  = 3
) (
    input  logic [NSRC-1:0]              req,
    input  logic [NSRC-1:0][PORT_W-1:0]  port,
    input  logic [NOUT-1:0]              space,
    output logic [NSRC-1:0]              ready,
    output logic [NOUT-1:0]              push,
    output logic [NOUT-1:0][SRC_W-1:0]   sel
);
    // A source is ready when its target has room and no lower-index
    // source is requesting the same target.
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            logic blocked;
            blocked = 1'b0;
            for (int t = 0; t < s; t++) begin
                if (req[t] && (port[t] == port[s])) blocked = 1'b1;
            end
            ready[s] = space[port[s]] && !blocked;
        end
    end

    always_comb begin
        for (int o = 0; o < NOUT; o++) begin
            push[o] = 1'b0;
            sel[o]  = '0;
            for (int s = NSRC - 1; s >= 0; s--) begin
                if (req[s] && ready[s] && (port[s] == PORT_W'(o))) begin
                    push[o] = 1'b1;
                    sel[o]  = SRC_W'(s);
                end
            end
        end
    end
endmodule

// File: rtl/lnk_out_fifo.sv
`timescale 1ns/1ps
module lnk_out_fifo import lnk_pkg::*; #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  pkt_t din,
    output logic space,
    output logic valid,
    input  logic pop,
    output pkt_t dout
);
    localparam int PTR_W = width_of(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    pkt_t               mem [DEPTH];
    logic [PTR_W-1:0]   wp, rp;
    logic [CNT_W-1:0]   cnt;
    logic               do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign space   = cnt < CNT_W'(DEPTH);
    assign valid   = cnt != '0;
    assign do_push = push && space;
    assign do_pop  = pop && valid;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= bump(wp);
            end
            if (do_pop) rp <= bump(rp);
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/lnk_router.sv
`timescale 1ns/1ps
module lnk_router import lnk_pkg::*; #(
    parameter  int NLINK  = LNK_NLINK,
    parameter  int DEPTH  = 2,
    localparam int LINK_W = width_of(NLINK)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [LNK_NODE_W-1:0]          my_node,
    input  logic                           map_we,
    input  logic [LNK_NODE_W-1:0]          map_node,
    input  logic [LINK_W-1:0]              map_link,
    input  logic [NLINK-1:0]               lk_rx_valid,
    output logic [NLINK-1:0]               lk_rx_ready,
    input  logic [NLINK-1:0][PKT_W-1:0]    lk_rx_pkt,
    output logic [NLINK-1:0]               lk_tx_valid,
    input  logic [NLINK-1:0]               lk_tx_ready,
    output logic [NLINK-1:0][PKT_W-1:0]    lk_tx_pkt,
    input  logic                           loc_rx_valid,
    output logic                           loc_rx_ready,
    input  logic [PKT_W-1:0]               loc_rx_pkt,
    output logic                           loc_tx_valid,
    input  logic                           loc_tx_ready,
    output logic [PKT_W-1:0]               loc_tx_pkt
);
    localparam int NSRC   = NLINK + 1;
    localparam int NOUT   = NLINK + 1;
    localparam int PORT_W = width_of(NOUT);
    localparam int SRC_W  = width_of(NSRC);

    logic [NSRC-1:0]                   src_valid, src_ready, src_fire;
    pkt_t                              src_pkt [NSRC];
    logic [NSRC-1:0][LNK_NODE_W-1:0]   src_node;
    logic [NSRC-1:0][PORT_W-1:0]       src_port;

    logic [NOUT-1:0]                   out_space, out_push, out_valid, out_pop;
    logic [NOUT-1:0][SRC_W-1:0]        out_sel;
    pkt_t                              out_din  [NOUT];
    pkt_t                              out_dout [NOUT];

    // Sources: links first, local injection last (lowest priority).
    generate
        for (genvar s = 0; s < NLINK; s++) begin : g_src
            assign src_valid[s] = lk_rx_valid[s];
            assign src_pkt[s]   = pkt_t'(lk_rx_pkt[s]);
        end
    endgenerate
    assign src_valid[NLINK] = loc_rx_valid;
    assign src_pkt[NLINK]   = pkt_t'(loc_rx_pkt);

    always_comb begin
        for (int s = 0; s < NSRC; s++) src_node[s] = src_pkt[s].node;
    end

    assign src_fire     = src_valid & src_ready;
    assign lk_rx_ready  = src_ready[NLINK-1:0];
    assign loc_rx_ready = src_ready[NLINK];

    lnk_route_map #(
        .NLINK (NLINK),
        .NSRC  (NSRC),
        .PORT_W(PORT_W),
        .LINK_W(LINK_W)
    ) u_map (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (map_we),
        .wr_node(map_node),
        .wr_link(map_link),
        .my_node(my_node),
        .q_node (src_node),
        .q_port (src_port)
    );

    lnk_arb #(
        .NSRC  (NSRC),
        .NOUT  (NOUT),
        .PORT_W(PORT_W),
        .SRC_W (SRC_W)
    ) u_arb (
        .req  (src_valid),
        .port (src_port),
        .space(out_space),
        .ready(src_ready),
        .push (out_push),
        .sel  (out_sel)
    );

    generate
        for (genvar o = 0; o < NOUT; o++) begin : g_out
            assign out_din[o] = src_pkt[out_sel[o]];
            lnk_out_fifo #(.DEPTH(DEPTH)) u_fifo (
                .clk  (clk),
                .rst  (rst),
                .push (out_push[o]),
                .din  (out_din[o]),
                .space(out_space[o]),
                .valid(out_valid[o]),
                .pop  (out_pop[o]),
                .dout (out_dout[o])
            );
        end
        for (genvar l = 0; l < NLINK; l++) begin : g_tx
            assign lk_tx_valid[l] = out_valid[l];
            assign lk_tx_pkt[l]   = out_dout[l];
            assign out_pop[l]     = out_valid[l] && lk_tx_ready[l];
        end
    endgenerate

    assign loc_tx_valid   = out_valid[NLINK];
    assign loc_tx_pkt     = out_dout[NLINK];
    assign out_pop[NLINK] = out_valid[NLINK] && loc_tx_ready;
endmodule

// File: rtl/lnk_router_chk.sv
`timescale 1ns/1ps
module lnk_router_chk import lnk_pkg::*; #(
    parameter  int NLINK  = LNK_NLINK,
    localparam int NSRC   = NLINK + 1,
    localparam int NOUT   = NLINK + 1,
    localparam int PORT_W = width_of(NOUT)
) (
    input logic                          clk,
    input logic                          rst,
    input logic [LNK_NODE_W-1:0]         my_node,
    input logic [NLINK-1:0]              lk_tx_valid,
    input logic [NLINK-1:0]              lk_tx_ready,
    input logic [NLINK-1:0][PKT_W-1:0]   lk_tx_pkt,
    input logic                          loc_tx_valid,
    input logic                          loc_tx_ready,
    input logic [PKT_W-1:0]              loc_tx_pkt,
    input logic [NSRC-1:0]               src_fire,
    input logic [NSRC-1:0][PORT_W-1:0]   src_port
);
    pkt_t loc_p;
    logic [NOUT-1:0][NSRC-1:0] hit;

    assign loc_p = pkt_t'(loc_tx_pkt);

    always_comb begin
        for (int o = 0; o < NOUT; o++)
            for (int s = 0; s < NSRC; s++)
                hit[o][s] = src_fire[s] && (src_port[s] == PORT_W'(o));
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lk_tx_valid == '0) && !loc_tx_valid);

    // R2
    local_owner_chk: assert property (@(posedge clk) disable iff (rst)
        loc_tx_valid |-> (loc_p.node == my_node));

    // R9
    local_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (loc_tx_valid && !loc_tx_ready) |=> (loc_tx_valid && $stable(loc_tx_pkt)));

    generate
        for (genvar l = 0; l < NLINK; l++) begin : g_lk
            pkt_t lp;
            assign lp = pkt_t'(lk_tx_pkt[l]);

            // R3
            remote_only_chk: assert property (@(posedge clk) disable iff (rst)
                lk_tx_valid[l] |-> (lp.node != my_node));

            // R9
            link_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (lk_tx_valid[l] && !lk_tx_ready[l]) |=> (lk_tx_valid[l] && $stable(lk_tx_pkt[l])));
        end
        for (genvar o = 0; o < NOUT; o++) begin : g_one
            // R6
            single_grant_chk: assert property (@(posedge clk) disable iff (rst)
                $countones(hit[o]) <= 1);
        end
    endgenerate
endmodule

bind lnk_router lnk_router_chk #(.NLINK(NLINK)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .my_node     (my_node),
    .lk_tx_valid (lk_tx_valid),
    .lk_tx_ready (lk_tx_ready),
    .lk_tx_pkt   (lk_tx_pkt),
    .loc_tx_valid(loc_tx_valid),
    .loc_tx_ready(loc_tx_ready),
    .loc_tx_pkt  (loc_tx_pkt),
    .src_fire    (src_fire),
    .src_port    (src_port)
);

// File: tb/lnk_router_tb.sv
`timescale 1ns/1ps
module lnk_router_tb;
    import lnk_pkg::*;

    localparam int NL = LNK_NLINK;
    localparam int NS = NL + 1;
    localparam int PW = PKT_W;
    localparam logic [5:0] ME = 6'd9;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                    rst = 1'b1;
    logic [5:0]              my_node = ME;
    logic                    map_we = 1'b0;
    logic [5:0]              map_node = '0;
    logic [1:0]              map_link = '0;
    logic [NL-1:0]           lk_rx_valid = '0;
    logic [NL-1:0]           lk_rx_ready;
    logic [NL-1:0][PW-1:0]   lk_rx_pkt = '0;
    logic [NL-1:0]           lk_tx_valid;
    logic [NL-1:0]           lk_tx_ready = '0;
    logic [NL-1:0][PW-1:0]   lk_tx_pkt;
    logic                    loc_rx_valid = 1'b0;
    logic                    loc_rx_ready;
    logic [PW-1:0]           loc_rx_pkt = '0;
    logic                    loc_tx_valid;
    logic                    loc_tx_ready = 1'b0;
    logic [PW-1:0]           loc_tx_pkt;

    lnk_router u_dut (
        .clk(clk), .rst(rst), .my_node(my_node),
        .map_we(map_we), .map_node(map_node), .map_link(map_link),
        .lk_rx_valid(lk_rx_valid), .lk_rx_ready(lk_rx_ready), .lk_rx_pkt(lk_rx_pkt),
        .lk_tx_valid(lk_tx_valid), .lk_tx_ready(lk_tx_ready), .lk_tx_pkt(lk_tx_pkt),
        .loc_rx_valid(loc_rx_valid), .loc_rx_ready(loc_rx_ready), .loc_rx_pkt(loc_rx_pkt),
        .loc_tx_valid(loc_tx_valid), .loc_tx_ready(loc_tx_ready), .loc_tx_pkt(loc_tx_pkt)
    );

    // Reference model state
    logic [PW-1:0] srcq [NS][$];
    logic [PW-1:0] outq [NS][$];
    int            mtab [64];
    bit [NS-1:0]   sink_rdy = '1;
    bit            rst_drv = 1'b1;
    bit            cfg_we = 1'b0;
    int            cfg_node = 0;
    int            cfg_link = 0;
    int            nchk = 0;
    int            nerr = 0;
    string         req = "R1";
    bit            done = 1'b0;

    function automatic logic [PW-1:0] mk(logic [1:0] k, int src, int tag, int node, int word, int data);
        pkt_t p;
        p.kind = pkt_kind_e'(k);
        p.src  = 6'(src);
        p.tag  = 4'(tag);
        p.node = 6'(node);
        p.word = 24'(word);
        p.data = 32'(data);
        return PW'(p);
    endfunction

    function automatic int dest_of(logic [PW-1:0] p);
        pkt_t q;
        q = pkt_t'(p);
        return (q.node == ME) ? NL : mtab[q.node];
    endfunction

    task automatic chk(string what, logic [PW-1:0] act, logic [PW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        bit [NS-1:0]   v, r, fire, pop;
        logic [PW-1:0] hp [NS];
        int            d  [NS];
        @(negedge clk);
        rst = rst_drv;
        for (int s = 0; s < NS; s++) begin
            v[s]  = srcq[s].size() > 0;
            hp[s] = v[s] ? srcq[s][0] : '0;
        end
        for (int l = 0; l < NL; l++) begin
            lk_rx_valid[l] = v[l];
            lk_rx_pkt[l]   = hp[l];
        end
        loc_rx_valid = v[NL];
        loc_rx_pkt   = hp[NL];
        lk_tx_ready  = sink_rdy[NL-1:0];
        loc_tx_ready = sink_rdy[NL];
        map_we   = cfg_we;
        map_node = 6'(cfg_node);
        map_link = 2'(cfg_link);
        #1;
        for (int o = 0; o < NS; o++) begin
            bit            ev, av;
            logic [PW-1:0] ap;
            ev = outq[o].size() > 0;
            av = (o < NL) ? lk_tx_valid[o] : loc_tx_valid;
            ap = (o < NL) ? lk_tx_pkt[o] : loc_tx_pkt;
            chk($sformatf("out%0d valid", o), PW'(av), PW'(ev));
            if (ev) chk($sformatf("out%0d packet", o), ap, outq[o][0]);
            pop[o] = ev && sink_rdy[o];
        end
        for (int s = 0; s < NS; s++) begin
            d[s] = dest_of(hp[s]);
            r[s] = outq[d[s]].size() < 2;
            for (int t = 0; t < s; t++)
                if (v[t] && d[t] == d[s]) r[s] = 1'b0;
            if (v[s] && !rst_drv)
                chk($sformatf("src%0d ready", s),
                    PW'((s < NL) ? lk_rx_ready[s] : loc_rx_ready), PW'(r[s]));
            fire[s] = v[s] && r[s] && !rst_drv;
        end
        @(posedge clk);
        if (!rst_drv) begin
            for (int o = 0; o < NS; o++)
                if (pop[o]) void'(outq[o].pop_front());
            for (int s = 0; s < NS; s++)
                if (fire[s]) begin
                    outq[d[s]].push_back(hp[s]);
                    void'(srcq[s].pop_front());
                end
            if (cfg_we) mtab[cfg_node] = cfg_link;
        end
        cfg_we = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic program_map(int node, int link);
        cfg_we = 1'b1; cfg_node = node; cfg_link = link;
        step();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mtab[i] = 0;
        // R1: reset state, outputs idle
        req = "R1";
        rst_drv = 1'b1;
        run(3);
        rst_drv = 1'b0;
        run(2);

        // R4: default entry is link 0; write takes effect the cycle after
        req = "R4";
        srcq[NL].push_back(mk(2'b01, 9, 1, 5, 'h100, 'h11));
        run(3);
        srcq[NL].push_back(mk(2'b01, 9, 2, 5, 'h101, 'h22));
        cfg_we = 1'b1; cfg_node = 5; cfg_link = 2;
        step();
        srcq[NL].push_back(mk(2'b01, 9, 3, 5, 'h102, 'h33));
        run(4);

        // R2: packets for this node, from a link and looped back locally
        req = "R2";
        srcq[1].push_back(mk(2'b01, 3, 4, 9, 'h200, 'h44));
        srcq[NL].push_back(mk(2'b10, 9, 5, 9, 'h201, 0));
        run(4);

        // R3: table-driven forwarding, including transit
        req = "R3";
        program_map(12, 3);
        program_map(20, 1);
        program_map(33, 0);
        program_map(40, 2);
        srcq[2].push_back(mk(2'b01, 1, 6, 12, 'h300, 'h55));
        srcq[0].push_back(mk(2'b01, 2, 7, 20, 'h301, 'h66));
        srcq[NL].push_back(mk(2'b01, 9, 8, 33, 'h302, 'h77));
        run(4);

        // R8: every source to a different output in one cycle
        req = "R8";
        srcq[0].push_back(mk(2'b01, 1, 1, 12, 'h400, 1));
        srcq[1].push_back(mk(2'b01, 1, 2, 9,  'h401, 2));
        srcq[2].push_back(mk(2'b01, 1, 3, 20, 'h402, 3));
        srcq[3].push_back(mk(2'b01, 1, 4, 33, 'h403, 4));
        srcq[NL].push_back(mk(2'b01, 9, 5, 40, 'h404, 5));
        run(4);

        // R5: full output back-pressures, order kept, nothing dropped
        req = "R5";
        sink_rdy[3] = 1'b0;
        for (int i = 0; i < 4; i++)
            srcq[2].push_back(mk(2'b01, 1, i, 12, 'h500 + i, 'hA0 + i));
        run(3);
        // R9: stalled output holds its packet
        req = "R9";
        run(3);
        req = "R5";
        sink_rdy[3] = 1'b1;
        run(6);

        // R6: five sources contend for one output
        req = "R6";
        for (int s = 0; s < NS; s++)
            srcq[s].push_back(mk(2'b01, s, s, 20, 'h600 + s, 'hB0 + s));
        sink_rdy[1] = 1'b0;
        run(2);
        sink_rdy[1] = 1'b1;
        run(10);

        // R7: read request out, read return back by requester node
        req = "R7";
        srcq[NL].push_back(mk(2'b10, 9, 5, 33, 'h700, 0));
        run(2);
        srcq[0].push_back(mk(2'b11, 33, 5, 9, 'h700, 'hCAFE));
        srcq[3].push_back(mk(2'b11, 12, 7, 20, 'h701, 'hBEEF));
        sink_rdy[NL] = 1'b0;
        srcq[2].push_back(mk(2'b10, 40, 2, 9, 'h702, 0));
        run(4);
        sink_rdy[NL] = 1'b1;
        run(6);

        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule